// File: doc/BRIEF.md
# Stop Mode Power Controller

This block chooses the low-power level the chip drops into when the processor issues a stop request. It then drives the clock gates, the regulator standby request, the RAM supply, the pin-hold control and the periodic-wakeup timer clock that belong to that level. The stop request carries two level-select bits. Two protection bits are captured at the moment of entry: the debug-enable bit and the low-voltage-reset-enable bit. If either one is set, the deep levels are refused and the chip parks in the shallow level instead. A set debug-enable bit also keeps the debug clock running and the regulator at full output. A set low-voltage-reset-enable bit keeps the regulator out of standby.

The controller also tracks the wait state and the active-debug state. It reports the current mode as a 3-bit code. It answers debug memory-access requests with either a grant or a low-power error. The shallow level and the wait state are left by a wake interrupt or a debug wake command. The deep levels are left only through reset. All outputs are registered and change on the same clock edge as the mode code.

Top module: `stop_pwr_ctrl`

## Requirements
- R1: Mode codes on `mode_stat` are run=0, wait=1, stop1=2, stop2=3, stop3=4, active-debug=5. In run, with both protection bits clear, a `stop_req` moves to a level chosen by the select bits on the next edge: `pd_sel`=0 gives stop3, `pd_sel`=1 with `ppd_sel`=1 gives stop2, and `pd_sel`=1 with `ppd_sel`=0 gives stop1.
- R2: If `dbg_en` or `lvr_en` is 1 when `stop_req` is taken, the mode becomes stop3 whatever the select bits are.
- R3: `cpu_clk_en` and `per_clk_en` are 1 in run and active-debug. In wait, `cpu_clk_en` is 0 and `per_clk_en` is 1. In every stop level both are 0, including when the debug clock stays on.
- R4: `dbg_clk_en` is 1 outside the stop levels. In stop3 it equals the `dbg_en` value captured at entry. In stop1 and stop2 it is 0.
- R5: `reg_stby` is 1 in a stop level unless the captured `dbg_en` or the captured `lvr_en` is 1. Outside the stop levels it is 0.
- R6: `ram_on` is 0 only in stop1. `io_hold` is 1 in every stop level and 0 otherwise. `rti_clk_en` takes the `rti_en` value of the previous cycle, except that it is 0 when the new mode is stop1.
- R7: In stop3 or wait, `irq_wake` returns the mode to run on the next edge, with all clocks back on. In stop1 and stop2, `irq_wake` and `dbg_bkgd` have no effect.
- R8: `dbg_bkgd` enters active-debug from run or wait when `dbg_en` is 1, and from stop3 when the captured `dbg_en` is 1. Otherwise it is ignored. It takes priority over `irq_wake`. In active-debug, `dbg_go` returns the mode to run.
- R9: Changes to `dbg_en` and `lvr_en` during a stop level change none of the outputs.
- R10: One cycle after `dbg_mem_req`, `dbg_mem_err`=1 and `dbg_mem_grant`=0 if the mode was wait or any stop level. Otherwise `dbg_mem_grant`=1 and `dbg_mem_err`=0. With no request, both are 0.
- R11: In run, `stop_req` beats `wait_req`, and `wait_req` beats `dbg_bkgd`. A `wait_req` alone enters wait.
- R12: A `rst` sampled high at a clock edge forces run, all clocks on, `reg_stby`=0, `ram_on`=1, `io_hold`=0, `rti_clk_en`=0 and both debug responses 0, from any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | Stop instruction strobe |
| wait_req | input | 1 | Wait instruction strobe |
| pd_sel | input | 1 | Power-down select |
| ppd_sel | input | 1 | Partial power-down select |
| dbg_en | input | 1 | Debug enable |
| lvr_en | input | 1 | Low-voltage reset enable |
| rti_en | input | 1 | Periodic wakeup timer enable |
| irq_wake | input | 1 | Enabled wake interrupt |
| dbg_bkgd | input | 1 | Debug wake command strobe |
| dbg_go | input | 1 | Debug resume command strobe |
| dbg_mem_req | input | 1 | Debug memory-access request |
| cpu_clk_en | output | 1 | CPU clock gate |
| per_clk_en | output | 1 | Digital peripheral clock gate |
| dbg_clk_en | output | 1 | Debug logic clock gate |
| reg_stby | output | 1 | Regulator standby request |
| ram_on | output | 1 | RAM supply enable |
| io_hold | output | 1 | Pin state hold |
| rti_clk_en | output | 1 | Wakeup timer clock enable |
| mode_stat | output | 3 | Current mode code |
| dbg_mem_grant | output | 1 | Debug access performed |
| dbg_mem_err | output | 1 | Debug access refused, low-power error |

## Verification
Every result is due one edge after its cause. The mode code and all gates follow a strobe or wake input on the next edge. `rti_clk_en` follows `rti_en` one edge later. The debug response follows `dbg_mem_req` one edge later and is judged against the mode that was current when the request was made. The bench drives inputs one time unit after a rising edge. A behavioural model advances on the same edge and is compared at the falling edge, so each expected value is read exactly in the cycle it becomes due.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    M_RUN   = 3'd0,
    M_WAIT  = 3'd1,
    M_STOP1 = 3'd2,
    M_STOP2 = 3'd3,
    M_STOP3 = 3'd4,
    M_DBG   = 3'd5
  } mode_e;

  typedef struct packed {
    logic cpu;
    logic per;
    logic dbg;
    logic stby;
    logic ram;
    logic hold;
    logic rti;
  } gate_t;

  function automatic logic is_stop(mode_e m);
    return (m == M_STOP1) || (m == M_STOP2) || (m == M_STOP3);
  endfunction
endpackage

// File: rtl/spc_level_sel.sv
module spc_level_sel
  import spc_pkg::*;
(
  input  logic  pd_sel,
  input  logic  ppd_sel,
  input  logic  dbg_en,
  input  logic  lvr_en,
  output mode_e lvl
);
  always_comb begin
    if (!pd_sel || dbg_en || lvr_en) lvl = M_STOP3;
    else if (ppd_sel)                lvl = M_STOP2;
    else                             lvl = M_STOP1;
  end
endmodule

// File: rtl/spc_fsm.sv
module spc_fsm
  import spc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  stop_req,
  input  logic  wait_req,
  input  logic  irq_wake,
  input  logic  dbg_bkgd,
  input  logic  dbg_go,
  input  logic  dbg_en,
  input  logic  lvr_en,
  input  mode_e lvl,
  output mode_e mode_q,
  output mode_e mode_d,
  output logic  dbg_held_d,
  output logic  lvr_held_d
);
  logic dbg_held_q, lvr_held_q;

  always_comb begin
    mode_d     = mode_q;
    dbg_held_d = dbg_held_q;
    lvr_held_d = lvr_held_q;
    case (mode_q)
      M_RUN: begin
        if (stop_req) begin
          mode_d     = lvl;
          dbg_held_d = dbg_en;
          lvr_held_d = lvr_en;
        end else if (wait_req) begin
          mode_d = M_WAIT;
        end else if (dbg_bkgd && dbg_en) begin
          mode_d = M_DBG;
        end
      end
      M_WAIT: begin
        if (dbg_bkgd && dbg_en) mode_d = M_DBG;
        else if (irq_wake)      mode_d = M_RUN;
      end
      M_STOP3: begin
        if (dbg_bkgd && dbg_held_q) mode_d = M_DBG;
        else if (irq_wake)          mode_d = M_RUN;
      end
      M_STOP1, M_STOP2: mode_d = mode_q;
      M_DBG: begin
        if (dbg_go) mode_d = M_RUN;
      end
      default: mode_d = M_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= M_RUN;
      dbg_held_q <= 1'b0;
      lvr_held_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      dbg_held_q <= dbg_held_d;
      lvr_held_q <= lvr_held_d;
    end
  end
endmodule

// File: rtl/spc_gate_out.sv
module spc_gate_out
  import spc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode_d,
  input  logic  dbg_held_d,
  input  logic  lvr_held_d,
  input  logic  rti_en,
  output gate_t gate_q
);
  gate_t nxt;
  logic  stp;

  always_comb begin
    stp      = is_stop(mode_d);
    nxt.cpu  = (mode_d == M_RUN) || (mode_d == M_DBG);
    nxt.per  = (mode_d == M_RUN) || (mode_d == M_WAIT) || (mode_d == M_DBG);
    nxt.dbg  = stp ? ((mode_d == M_STOP3) && dbg_held_d) : 1'b1;
    nxt.stby = stp && !(dbg_held_d || lvr_held_d);
    nxt.ram  = (mode_d != M_STOP1);
    nxt.hold = stp;
    nxt.rti  = rti_en && (mode_d != M_STOP1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '{cpu: 1'b1, per: 1'b1, dbg: 1'b1, stby: 1'b0,
                  ram: 1'b1, hold: 1'b0, rti: 1'b0};
    end else begin
      gate_q <= nxt;
    end
  end
endmodule

// File: rtl/spc_dbg_resp.sv
module spc_dbg_resp
  import spc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  req,
  input  mode_e mode_q,
  output logic  grant,
  output logic  err
);
  logic lowpwr;
  assign lowpwr = (mode_q == M_WAIT) || is_stop(mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      err   <= 1'b0;
    end else begin
      grant <= req && !lowpwr;
      err   <= req && lowpwr;
    end
  end
endmodule

// File: rtl/stop_pwr_ctrl.sv
module stop_pwr_ctrl
  import spc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_req,
  input  logic       wait_req,
  input  logic       pd_sel,
  input  logic       ppd_sel,
  input  logic       dbg_en,
  input  logic       lvr_en,
  input  logic       rti_en,
  input  logic       irq_wake,
  input  logic       dbg_bkgd,
  input  logic       dbg_go,
  input  logic       dbg_mem_req,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       dbg_clk_en,
  output logic       reg_stby,
  output logic       ram_on,
  output logic       io_hold,
  output logic       rti_clk_en,
  output logic [2:0] mode_stat,
  output logic       dbg_mem_grant,
  output logic       dbg_mem_err
);
  mode_e lvl, mode_q, mode_d;
  logic  dbg_held_d, lvr_held_d;
  gate_t gate_q;

  spc_level_sel u_lvl (
    .pd_sel(pd_sel), .ppd_sel(ppd_sel), .dbg_en(dbg_en), .lvr_en(lvr_en), .lvl(lvl)
  );

  spc_fsm u_fsm (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wait_req(wait_req),
    .irq_wake(irq_wake), .dbg_bkgd(dbg_bkgd), .dbg_go(dbg_go),
    .dbg_en(dbg_en), .lvr_en(lvr_en), .lvl(lvl),
    .mode_q(mode_q), .mode_d(mode_d),
    .dbg_held_d(dbg_held_d), .lvr_held_d(lvr_held_d)
  );

  spc_gate_out u_gate (
    .clk(clk), .rst(rst), .mode_d(mode_d), .dbg_held_d(dbg_held_d),
    .lvr_held_d(lvr_held_d), .rti_en(rti_en), .gate_q(gate_q)
  );

  spc_dbg_resp u_resp (
    .clk(clk), .rst(rst), .req(dbg_mem_req), .mode_q(mode_q),
    .grant(dbg_mem_grant), .err(dbg_mem_err)
  );

  assign mode_stat  = mode_q;
  assign cpu_clk_en = gate_q.cpu;
  assign per_clk_en = gate_q.per;
  assign dbg_clk_en = gate_q.dbg;
  assign reg_stby   = gate_q.stby;
  assign ram_on     = gate_q.ram;
  assign io_hold    = gate_q.hold;
  assign rti_clk_en = gate_q.rti;
endmodule

// File: rtl/spc_checker.sv
module spc_checker (
  input logic       clk,
  input logic       rst,
  input logic       stop_req,
  input logic       dbg_en,
  input logic       lvr_en,
  input logic       irq_wake,
  input logic       dbg_bkgd,
  input logic       dbg_mem_req,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       dbg_clk_en,
  input logic       reg_stby,
  input logic [2:0] mode_stat,
  input logic       dbg_mem_err,
  input logic       dbg_mem_grant
);
  logic in_stop;
  assign in_stop = (mode_stat == 3'd2) || (mode_stat == 3'd3) || (mode_stat == 3'd4);

  // R2: protected entry always lands in the shallow level
  assert_demote_R2: assert property (@(posedge clk) disable iff (rst)
    (stop_req && mode_stat == 3'd0 && (dbg_en || lvr_en)) |=> (mode_stat == 3'd4));

  // R3: no CPU or peripheral clock in any stop level
  assert_stop_clk_off_R3: assert property (@(posedge clk) disable iff (rst)
    in_stop |-> (!cpu_clk_en && !per_clk_en));

  // R5: a live debug clock in stop implies full regulation
  assert_dbg_full_reg_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_stat == 3'd4 && dbg_clk_en) |-> !reg_stby);

  // R7: deep level is left only by reset
  assert_stop1_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_stat == 3'd2) |=> (mode_stat == 3'd2));

  // R7: interrupt leaves stop3 with clocks on
  assert_wake_run_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_stat == 3'd4 && irq_wake && !dbg_bkgd) |=> (mode_stat == 3'd0 && cpu_clk_en));

  // R10: debug access in low power is refused
  assert_mem_err_R10: assert property (@(posedge clk) disable iff (rst)
    (dbg_mem_req && (in_stop || mode_stat == 3'd1)) |=> (dbg_mem_err && !dbg_mem_grant));
endmodule

bind stop_pwr_ctrl spc_checker u_chk (
  .clk(clk), .rst(rst), .stop_req(stop_req), .dbg_en(dbg_en), .lvr_en(lvr_en),
  .irq_wake(irq_wake), .dbg_bkgd(dbg_bkgd), .dbg_mem_req(dbg_mem_req),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .dbg_clk_en(dbg_clk_en),
  .reg_stby(reg_stby), .mode_stat(mode_stat), .dbg_mem_err(dbg_mem_err),
  .dbg_mem_grant(dbg_mem_grant)
);

// File: tb/sim_stop_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_stop_pwr_ctrl;
  logic clk = 0;
  logic rst = 1;
  logic stop_req = 0, wait_req = 0, pd_sel = 0, ppd_sel = 0, dbg_en = 0, lvr_en = 0;
  logic rti_en = 0, irq_wake = 0, dbg_bkgd = 0, dbg_go = 0, dbg_mem_req = 0;
  logic cpu_clk_en, per_clk_en, dbg_clk_en, reg_stby, ram_on, io_hold, rti_clk_en;
  logic [2:0] mode_stat;
  logic dbg_mem_grant, dbg_mem_err;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  stop_pwr_ctrl u0 (
    .clk(clk), .rst(rst), .stop_req(stop_req), .wait_req(wait_req), .pd_sel(pd_sel),
    .ppd_sel(ppd_sel), .dbg_en(dbg_en), .lvr_en(lvr_en), .rti_en(rti_en),
    .irq_wake(irq_wake), .dbg_bkgd(dbg_bkgd), .dbg_go(dbg_go), .dbg_mem_req(dbg_mem_req),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .dbg_clk_en(dbg_clk_en),
    .reg_stby(reg_stby), .ram_on(ram_on), .io_hold(io_hold), .rti_clk_en(rti_clk_en),
    .mode_stat(mode_stat), .dbg_mem_grant(dbg_mem_grant), .dbg_mem_err(dbg_mem_err)
  );

  // behavioural reference model
  int md = 0;
  bit hd = 0, hl = 0;
  bit e_cpu = 1, e_per = 1, e_dbg = 1, e_stby = 0, e_ram = 1, e_hold = 0, e_rti = 0;
  bit e_gnt = 0, e_err = 0;

  always @(posedge clk) begin
    int nm;
    bit lowp, stp;
    lowp = (md >= 1 && md <= 4);
    if (rst) begin
      nm = 0; hd = 0; hl = 0; e_gnt = 0; e_err = 0;
    end else begin
      nm = md;
      e_gnt = dbg_mem_req && !lowp;
      e_err = dbg_mem_req && lowp;
      if (md == 0) begin
        if (stop_req) begin
          hd = dbg_en; hl = lvr_en;
          if (dbg_en || lvr_en || !pd_sel) nm = 4;
          else nm = ppd_sel ? 3 : 2;
        end else if (wait_req) nm = 1;
        else if (dbg_bkgd && dbg_en) nm = 5;
      end else if (md == 1) begin
        if (dbg_bkgd && dbg_en) nm = 5; else if (irq_wake) nm = 0;
      end else if (md == 4) begin
        if (dbg_bkgd && hd) nm = 5; else if (irq_wake) nm = 0;
      end else if (md == 5) begin
        if (dbg_go) nm = 0;
      end
    end
    md = nm;
    stp = (md >= 2 && md <= 4);
    if (rst) begin
      e_cpu = 1; e_per = 1; e_dbg = 1; e_stby = 0; e_ram = 1; e_hold = 0; e_rti = 0;
    end else begin
      e_cpu  = (md == 0 || md == 5);
      e_per  = (md == 0 || md == 1 || md == 5);
      e_dbg  = stp ? (md == 4 && hd) : 1'b1;
      e_stby = stp && !(hd || hl);
      e_ram  = (md != 2);
      e_hold = stp;
      e_rti  = rti_en && (md != 2);
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp("R1 mode_stat", mode_stat, md);
    cmp("R3 cpu_clk_en", cpu_clk_en, e_cpu);
    cmp("R3 per_clk_en", per_clk_en, e_per);
    cmp("R4 dbg_clk_en", dbg_clk_en, e_dbg);
    cmp("R5 reg_stby", reg_stby, e_stby);
    cmp("R6 ram_on", ram_on, e_ram);
    cmp("R6 io_hold", io_hold, e_hold);
    cmp("R6 rti_clk_en", rti_clk_en, e_rti);
    cmp("R10 dbg_mem_grant", dbg_mem_grant, e_gnt);
    cmp("R10 dbg_mem_err", dbg_mem_err, e_err);
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
    stop_req = 0; wait_req = 0; irq_wake = 0; dbg_bkgd = 0; dbg_go = 0; dbg_mem_req = 0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    step(3); rst = 0; step(1);
    cmp("R12 reset mode", mode_stat, 0);
    // R1: stop3 then interrupt wake (R7)
    pd_sel = 0; stop_req = 1; rti_en = 1; step(1);
    cmp("R1 stop3 entry", mode_stat, 4);
    rti_en = 0; step(2);
    irq_wake = 1; step(1);
    cmp("R7 wake to run", mode_stat, 0);
    // R1: stop2; R7 irq and debug wake ignored
    pd_sel = 1; ppd_sel = 1; stop_req = 1; step(1);
    cmp("R1 stop2 entry", mode_stat, 3);
    irq_wake = 1; dbg_bkgd = 1; dbg_mem_req = 1; step(2);
    cmp("R7 stop2 held", mode_stat, 3);
    rst = 1; step(1); rst = 0;
    cmp("R12 reset from stop2", mode_stat, 0);
    // R1: stop1, only reset leaves
    ppd_sel = 0; stop_req = 1; rti_en = 1; step(1);
    cmp("R1 stop1 entry", mode_stat, 2);
    irq_wake = 1; step(3);
    rst = 1; step(1); rst = 0; step(1);
    // R2 debug demotion, R9 change during stop, R8 debug wake
    dbg_en = 1; stop_req = 1; step(1);
    cmp("R2 debug demote", mode_stat, 4);
    dbg_en = 0; step(2);
    cmp("R9 debug clock kept", dbg_clk_en, 1);
    dbg_bkgd = 1; irq_wake = 1; step(1);
    cmp("R8 debug wake priority", mode_stat, 5);
    dbg_mem_req = 1; step(1);
    cmp("R10 grant in debug", dbg_mem_grant, 1);
    dbg_go = 1; step(1);
    cmp("R8 resume run", mode_stat, 0);
    // R2 low-voltage demotion, R5 regulator, R9
    lvr_en = 1; ppd_sel = 1; stop_req = 1; step(1);
    cmp("R5 lvr regulator on", reg_stby, 0);
    lvr_en = 0; step(2);
    dbg_bkgd = 1; step(1);
    cmp("R8 ignored without debug", mode_stat, 4);
    irq_wake = 1; step(1);
    // R11 wait and priority, R10 error in wait
    wait_req = 1; dbg_en = 1; dbg_bkgd = 1; step(1);
    cmp("R11 wait beats debug", mode_stat, 1);
    dbg_mem_req = 1; step(1);
    cmp("R10 error in wait", dbg_mem_err, 1);
    irq_wake = 1; step(1);
    dbg_en = 0;
    stop_req = 1; wait_req = 1; pd_sel = 0; step(1);
    cmp("R11 stop beats wait", mode_stat, 4);
    cmp("R5 standby unprotected", reg_stby, 1);
    rti_en = 1; step(1); rti_en = 0; step(1);
    dbg_mem_req = 1; step(1);
    irq_wake = 1; step(1);
    dbg_en = 1; dbg_bkgd = 1; step(1);
    cmp("R8 debug from run", mode_stat, 5);
    dbg_go = 1; step(2);
    done = 1;
    summary();
    $finish;
  end
endmodule